// File: doc/BRIEF.md
# Pulse-Burst PWM Channel

A single pulse-width modulation channel driven through a small word-wide register port. A free-running counter advances at the system clock divided by an 8-bit prescale value plus one. It counts from zero up to a 16-bit period value and then wraps. The main output is active while the counter sits below a 16-bit compare value. A second output carries the logical complement of the main waveform, and each of the two outputs can be inverted on its own.

The channel has two operating modes. In continuous mode it repeats periods until software clears its enable bit. In burst mode it emits a programmed number of periods (a 14-bit count, written as a low byte and a high byte). After the last period it clears its own enable, parks both outputs at their idle levels and raises a sticky done flag. The flag is cleared by writing one to it. An interrupt line reflects the flag gated by a mask bit.

Period and compare writes go to holding registers. The counter picks them up only when a period begins, so a reprogramming never produces a shortened or stretched pulse.

Top module: `pwm_burst_chan`

## Requirements
- R1: After reset every register reads zero, the main output is 0, the complementary output is 1 and the interrupt line is 0.
- R2: Running continuously with prescale p, period P and compare C (0 < C <= P), the main output repeats a high run of C*(p+1) cycles followed by a low run of (P+1-C)*(p+1) cycles.
- R3: The counter advances once every p+1 clock cycles for any prescale value p from 0 to 255, and the prescale divider is held at zero while the channel is stopped.
- R4: A compare of 0 keeps the main output low for the whole run. A compare greater than the period keeps it high for the whole run.
- R5: A period or compare value written while the channel runs is applied at the next period boundary; the period in progress finishes with the old values.
- R6: With the mode register (address 7) holding code 0x01, the channel emits exactly N periods, where N = {pulse-high[5:0] at address 5, pulse-low[7:0] at address 4}. A count of 0 gives one period. After the last period, control bit 0 reads 0, the outputs rest at their idle levels and status bit 0 (address 6) reads 1.
- R7: Any mode code other than 0x01 (0x00 included) selects continuous operation, which never stops by itself.
- R8: Before inversion, the complementary output is the logical inverse of the main output at every cycle, including while the channel is idle.
- R9: Control bit 1 inverts only the main output and control bit 2 inverts only the complementary output. The inversion also applies to the idle levels.
- R10: Status bit 0 stays set until a write to address 6 with bit 0 set. A write with bit 0 clear leaves it set.
- R11: The interrupt output is 1 exactly when the done flag is set and control bit 3 (interrupt mask) is 1. It follows one cycle after either changes.
- R12: Writing control bit 0 as 0 stops the channel. Both outputs reach their idle levels within two cycles of the write, no further pulses appear and the done flag is not set.
- R13: Setting control bit 0 from 0 to 1 starts a new period at counter value zero, so the first active run after a start has full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address (0 control, 1 prescale, 2 period, 3 compare, 4 pulse low, 5 pulse high, 6 status, 7 mode) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address presented in the previous cycle |
| pwm_o | output | 1 | Main waveform output |
| pwm_n_o | output | 1 | Complementary waveform output |
| irq_o | output | 1 | Interrupt request, done flag gated by mask |

## Verification
Properties checked on every cycle:
- The counter never passes the loaded period.
- The loaded period and compare hold steady between period boundaries.
- The divider rests at zero while stopped.
- The two outputs keep their complementary relation under the current inversion bits.
- A stopped channel shows the idle level.
- The done flag is sticky.
- A burst end clears the enable and sets the flag.

The scenarios show what a per-cycle property cannot:
- measured run lengths for several prescale, period and compare sets;
- the exact pulse total of a burst with a count above 255;
- the moment a mid-period compare write takes effect;
- decoding of the mode code;
- write-one-to-clear behaviour and interrupt masking at the ports.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_PRESC  = 3'd1,
    RA_PERIOD = 3'd2,
    RA_CMP    = 3'd3,
    RA_PLS_LO = 3'd4,
    RA_PLS_HI = 3'd5,
    RA_STAT   = 3'd6,
    RA_MODE   = 3'd7
  } reg_addr_e;

  // control register bit positions
  localparam int CTL_EN    = 0;
  localparam int CTL_INV_M = 1;
  localparam int CTL_INV_N = 2;
  localparam int CTL_MASK  = 3;

  // mode codes
  localparam logic [7:0] MODE_CONT  = 8'h00;
  localparam logic [7:0] MODE_BURST = 8'h01;

endpackage

// File: rtl/pwmb_regs.sv
module pwmb_regs
  import pwmb_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 14,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               finish,
  output logic               enable,
  output logic               start,
  output logic               burst_mode,
  output logic               inv_main,
  output logic               inv_comp,
  output logic [PRESC_W-1:0] presc,
  output logic [CNT_W-1:0]   period,
  output logic [CNT_W-1:0]   compare,
  output logic [PULSE_W-1:0] pulse_num,
  output logic               irq
);

  localparam int HI_W = PULSE_W - 8;

  logic               en_q, invm_q, invn_q, mask_q, done_q, irq_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   period_q, cmp_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [7:0]         mode_q;
  logic [DATA_W-1:0]  rdata_q, rd_next;

  logic wr_ctrl, wr_stat;
  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_stat = bus_wr && (bus_addr == RA_STAT);

  assign start = wr_ctrl && bus_wdata[CTL_EN] && !en_q && !finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      invm_q   <= 1'b0;
      invn_q   <= 1'b0;
      mask_q   <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      presc_q  <= '0;
      period_q <= '0;
      cmp_q    <= '0;
      pulse_q  <= '0;
      mode_q   <= MODE_CONT;
    end else begin
      if (finish)       en_q <= 1'b0;
      else if (wr_ctrl) en_q <= bus_wdata[CTL_EN];
      if (wr_ctrl) begin
        invm_q <= bus_wdata[CTL_INV_M];
        invn_q <= bus_wdata[CTL_INV_N];
        mask_q <= bus_wdata[CTL_MASK];
      end
      if (bus_wr) begin
        case (bus_addr)
          RA_PRESC:  presc_q  <= bus_wdata[PRESC_W-1:0];
          RA_PERIOD: period_q <= bus_wdata[CNT_W-1:0];
          RA_CMP:    cmp_q    <= bus_wdata[CNT_W-1:0];
          RA_PLS_LO: pulse_q[7:0] <= bus_wdata[7:0];
          RA_PLS_HI: pulse_q[PULSE_W-1:8] <= bus_wdata[HI_W-1:0];
          RA_MODE:   mode_q   <= bus_wdata[7:0];
          default: ;
        endcase
      end
      if (finish)                       done_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) done_q <= 1'b0;
      irq_q <= done_q && mask_q;
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      RA_CTRL: begin
        rd_next[CTL_EN]    = en_q;
        rd_next[CTL_INV_M] = invm_q;
        rd_next[CTL_INV_N] = invn_q;
        rd_next[CTL_MASK]  = mask_q;
      end
      RA_PRESC:  rd_next[PRESC_W-1:0] = presc_q;
      RA_PERIOD: rd_next[CNT_W-1:0]   = period_q;
      RA_CMP:    rd_next[CNT_W-1:0]   = cmp_q;
      RA_PLS_LO: rd_next[7:0]         = pulse_q[7:0];
      RA_PLS_HI: rd_next[HI_W-1:0]    = pulse_q[PULSE_W-1:8];
      RA_STAT:   rd_next[0]           = done_q;
      RA_MODE:   rd_next[7:0]         = mode_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata  = rdata_q;
  assign enable     = en_q;
  assign burst_mode = (mode_q == MODE_BURST);
  assign inv_main   = invm_q;
  assign inv_comp   = invn_q;
  assign presc      = presc_q;
  assign period     = period_q;
  assign compare    = cmp_q;
  assign pulse_num  = pulse_q;
  assign irq        = irq_q;

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(wr_stat && bus_wdata[0])) |=> done_q);

  // R6
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> (!en_q && done_q));

endmodule

// File: rtl/pwmb_prescaler.sv
module pwmb_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + W'(1);
  end

  // R3
  div_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwmb_core.sv
module pwmb_core #(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               start,
  input  logic               tick,
  input  logic               burst_mode,
  input  logic [CNT_W-1:0]   period_in,
  input  logic [CNT_W-1:0]   compare_in,
  input  logic [PULSE_W-1:0] pulse_num,
  output logic               active,
  output logic               finish
);

  logic [CNT_W-1:0]   cnt_q, per_q, cmp_q;
  logic [PULSE_W-1:0] pls_q;
  logic [PULSE_W:0]   pls_next;
  logic               wrap;

  assign wrap     = run && tick && (cnt_q >= per_q);
  assign pls_next = {1'b0, pls_q} + {{PULSE_W{1'b0}}, 1'b1};
  assign finish   = wrap && burst_mode && (pls_next >= {1'b0, pulse_num});
  assign active   = run && (cnt_q < cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
      pls_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      per_q <= period_in;
      cmp_q <= compare_in;
      pls_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      per_q <= period_in;
      cmp_q <= compare_in;
      if (burst_mode) pls_q <= pls_next[PULSE_W-1:0];
    end else if (run && tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= per_q));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !start && !wrap) |=> ($stable(per_q) && $stable(cmp_q)));

endmodule

// File: rtl/pwmb_outstage.sv
module pwmb_outstage (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic inv_main,
  input  logic inv_comp,
  output logic main_o,
  output logic comp_o
);

  localparam int NOUT = 2;

  logic [NOUT-1:0] raw, inv, out_q;

  assign raw[0] = active;
  assign raw[1] = !active;
  assign inv[0] = inv_main;
  assign inv[1] = inv_comp;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) out_q[g] <= (g == 1);
      else     out_q[g] <= raw[g] ^ inv[g];
    end
  end

  assign main_o = out_q[0];
  assign comp_o = out_q[1];

  // R8
  comp_pair_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_q[0] ^ out_q[1]) == !(inv[0] ^ inv[1]))
             || ((out_q[0] ^ out_q[1]) == !($past(inv[0]) ^ $past(inv[1]))));

  // R12
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (out_q[0] == $past(inv[0])));

endmodule

// File: rtl/pwm_burst_chan.sv
module pwm_burst_chan
  import pwmb_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 14,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_o,
  output logic              pwm_n_o,
  output logic              irq_o
);

  logic               enable, start, burst_mode, inv_main, inv_comp;
  logic               tick, active, finish;
  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   period, compare;
  logic [PULSE_W-1:0] pulse_num;

  pwmb_regs #(
    .PRESC_W(PRESC_W), .CNT_W(CNT_W), .PULSE_W(PULSE_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .finish(finish), .enable(enable), .start(start),
    .burst_mode(burst_mode), .inv_main(inv_main), .inv_comp(inv_comp),
    .presc(presc), .period(period), .compare(compare),
    .pulse_num(pulse_num), .irq(irq_o)
  );

  pwmb_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .run(enable), .div(presc), .tick(tick)
  );

  pwmb_core #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_core (
    .clk(clk), .rst(rst), .run(enable), .start(start), .tick(tick),
    .burst_mode(burst_mode), .period_in(period), .compare_in(compare),
    .pulse_num(pulse_num), .active(active), .finish(finish)
  );

  pwmb_outstage u_out (
    .clk(clk), .rst(rst), .active(active),
    .inv_main(inv_main), .inv_comp(inv_comp),
    .main_o(pwm_o), .comp_o(pwm_n_o)
  );

endmodule

// File: tb/pwm_burst_chan_bench.sv
module pwm_burst_chan_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_o, pwm_n_o, irq_o;

  pwm_burst_chan u_pwm_burst_chan (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  typedef struct { logic lvl; int len; string req; } seg_t;
  seg_t exp_q[$];

  int  total = 0, bad = 0, cyc = 0, run_len = 0, rise_cnt = 0;
  bit  armed = 0, run_valid = 0, mon_sel = 0, done_all = 0;
  logic last_sig = 1'b0, prev_main = 1'b0, sig;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: measures run lengths and pops expected segments
  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000 && !done_all) begin
      chk(1'b0, "WD", "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (!rst) begin
      sig = mon_sel ? pwm_n_o : pwm_o;
      if (sig !== last_sig) begin
        if (run_valid && exp_q.size() > 0) begin
          seg_t s;
          s = exp_q.pop_front();
          chk((last_sig === s.lvl) && (run_len == s.len), s.req,
              $sformatf("run length at level %0d", s.lvl), run_len, s.len);
        end
        run_valid = armed;
        run_len   = 1;
        last_sig  = sig;
      end else begin
        run_len++;
      end
      if (pwm_o === 1'b1 && prev_main === 1'b0) rise_cnt++;
      prev_main = pwm_o;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic get_rise(output int r);
    @(posedge clk);
    r = rise_cnt;
  endtask

  task automatic push(input logic lvl, input int len, input string req);
    seg_t s;
    s.lvl = lvl; s.len = len; s.req = req;
    exp_q.push_back(s);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 6000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, req, "expected runs left unseen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // run a continuous pattern and measure two full periods from the start
  task automatic pattern(input int p, input int per, input int cmp,
                         input logic [15:0] ctl, input bit sel,
                         input logic act_lvl, input string req);
    wr(3'd1, 16'(p));
    wr(3'd2, 16'(per));
    wr(3'd3, 16'(cmp));
    wr(3'd0, ctl);
    idle(3);
    @(posedge clk);
    mon_sel = sel;
    @(posedge clk);
    armed = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      push(act_lvl, cmp * (p + 1), req);
      push(!act_lvl, (per + 1 - cmp) * (p + 1), req);
    end
    armed = 1'b1;
    wr(3'd0, ctl | 16'h1);
    drain(req);
    @(posedge clk);
    armed = 1'b0;
    wr(3'd0, ctl);
    idle(4);
  endtask

  initial begin
    logic [15:0] v;
    int r0, r1;
    bit seen;

    idle(4);
    @(negedge clk); rst = 1'b0;
    idle(2);

    // R1 reset state
    chk(pwm_o === 1'b0, "R1", "main output after reset", pwm_o, 0);
    chk(pwm_n_o === 1'b1, "R1", "comp output after reset", pwm_n_o, 1);
    chk(irq_o === 1'b0, "R1", "irq after reset", irq_o, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 16'h0, "R1", $sformatf("reg %0d after reset", a), v, 0);
    end

    // R2 / R13 basic continuous runs, R3 prescaler
    pattern(0, 9, 4, 16'h0, 1'b0, 1'b1, "R2");
    pattern(3, 5, 2, 16'h0, 1'b0, 1'b1, "R3");
    pattern(1, 7, 7, 16'h0, 1'b0, 1'b1, "R2");
    pattern(0, 6, 3, 16'h0, 1'b0, 1'b1, "R13");

    // R4 compare zero: never high
    wr(3'd1, 16'd0); wr(3'd2, 16'd5); wr(3'd3, 16'd0);
    get_rise(r0);
    wr(3'd0, 16'h1);
    idle(100);
    get_rise(r1);
    chk(r1 - r0 == 0, "R4", "rises with compare 0", r1 - r0, 0);
    chk(pwm_o === 1'b0, "R4", "level with compare 0", pwm_o, 0);
    wr(3'd0, 16'h0); idle(3);

    // R4 compare above period: stays high
    wr(3'd3, 16'd9);
    get_rise(r0);
    wr(3'd0, 16'h1);
    idle(3);
    seen = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (pwm_o !== 1'b1) seen = 1'b1;
    end
    chk(!seen, "R4", "dropped while compare above period", seen, 0);
    get_rise(r1);
    chk(r1 - r0 == 1, "R4", "rises with compare above period", r1 - r0, 1);
    wr(3'd0, 16'h0); idle(3);

    // R5 shadowed compare update
    wr(3'd1, 16'd0); wr(3'd2, 16'd9); wr(3'd3, 16'd4);
    armed = 1'b0; mon_sel = 1'b0;
    wr(3'd0, 16'h1);
    while (pwm_o !== 1'b0) @(negedge clk);
    while (pwm_o !== 1'b1) @(negedge clk);
    wr(3'd3, 16'd7);
    @(posedge clk);
    push(1'b0, 6, "R5");
    push(1'b1, 7, "R5");
    push(1'b0, 3, "R5");
    push(1'b1, 7, "R5");
    armed = 1'b1;
    drain("R5");
    @(posedge clk); armed = 1'b0;
    wr(3'd0, 16'h0); idle(4);

    // R6 burst of 259 periods, mask on
    wr(3'd7, 16'h01);
    wr(3'd1, 16'd1); wr(3'd2, 16'd4); wr(3'd3, 16'd2);
    wr(3'd4, 16'h03); wr(3'd5, 16'h01);
    get_rise(r0);
    wr(3'd0, 16'h9);
    for (int i = 0; i < 5000; i++) begin
      rd(3'd6, v);
      if (v[0]) break;
    end
    idle(20);
    get_rise(r1);
    chk(r1 - r0 == 259, "R6", "pulses in burst", r1 - r0, 259);
    chk(pwm_o === 1'b0, "R6", "main idle after burst", pwm_o, 0);
    chk(pwm_n_o === 1'b1, "R6", "comp idle after burst", pwm_n_o, 1);
    rd(3'd0, v);
    chk(v[0] == 1'b0, "R6", "enable after burst", v[0], 0);
    rd(3'd6, v);
    chk(v[0] == 1'b1, "R6", "done flag after burst", v[0], 1);
    chk(irq_o === 1'b1, "R11", "irq with mask and done", irq_o, 1);

    // R10 write-one-to-clear
    wr(3'd6, 16'h0);
    rd(3'd6, v);
    chk(v[0] == 1'b1, "R10", "done after writing 0", v[0], 1);
    wr(3'd6, 16'h1);
    rd(3'd6, v);
    chk(v[0] == 1'b0, "R10", "done after writing 1", v[0], 0);
    idle(2);
    chk(irq_o === 1'b0, "R11", "irq after clear", irq_o, 0);

    // R6 count zero gives one period; R11 masked irq stays low
    wr(3'd1, 16'd0);
    wr(3'd4, 16'h00); wr(3'd5, 16'h00);
    get_rise(r0);
    wr(3'd0, 16'h1);
    idle(60);
    get_rise(r1);
    chk(r1 - r0 == 1, "R6", "pulses with count 0", r1 - r0, 1);
    rd(3'd6, v);
    chk(v[0] == 1'b1, "R6", "done with count 0", v[0], 1);
    chk(irq_o === 1'b0, "R11", "irq with mask clear", irq_o, 0);
    wr(3'd0, 16'h8);
    idle(3);
    chk(irq_o === 1'b1, "R11", "irq after mask set", irq_o, 1);
    wr(3'd6, 16'h1);
    wr(3'd0, 16'h0);

    // R7 other mode codes run continuously
    wr(3'd7, 16'h02);
    wr(3'd4, 16'h01);
    get_rise(r0);
    wr(3'd0, 16'h1);
    idle(200);
    get_rise(r1);
    chk(r1 - r0 >= 30, "R7", "pulses with mode 0x02", r1 - r0, 30);
    rd(3'd0, v);
    chk(v[0] == 1'b1, "R7", "enable with mode 0x02", v[0], 1);
    rd(3'd6, v);
    chk(v[0] == 1'b0, "R7", "done with mode 0x02", v[0], 0);
    wr(3'd0, 16'h0);
    wr(3'd7, 16'h00);
    idle(4);

    // R9 inversion of main only
    wr(3'd0, 16'h2); idle(3);
    chk(pwm_o === 1'b1, "R9", "inverted main idle", pwm_o, 1);
    chk(pwm_n_o === 1'b1, "R9", "comp idle with main inverted", pwm_n_o, 1);
    pattern(0, 7, 3, 16'h2, 1'b0, 1'b0, "R9");
    // R9 inversion of comp only
    wr(3'd0, 16'h4); idle(3);
    chk(pwm_o === 1'b0, "R9", "main idle with comp inverted", pwm_o, 0);
    chk(pwm_n_o === 1'b0, "R9", "inverted comp idle", pwm_n_o, 0);
    pattern(1, 5, 2, 16'h4, 1'b1, 1'b1, "R9");
    // R8 comp output waveform, no inversion
    pattern(0, 8, 5, 16'h0, 1'b1, 1'b0, "R8");

    // R12 stop mid-pulse
    wr(3'd1, 16'd0); wr(3'd2, 16'd9); wr(3'd3, 16'd6);
    @(posedge clk); mon_sel = 1'b0;
    wr(3'd0, 16'h1);
    while (pwm_o !== 1'b0) @(negedge clk);
    while (pwm_o !== 1'b1) @(negedge clk);
    wr(3'd0, 16'h0);
    @(negedge clk);
    chk(pwm_o === 1'b0, "R12", "main after stop", pwm_o, 0);
    chk(pwm_n_o === 1'b1, "R12", "comp after stop", pwm_n_o, 1);
    get_rise(r0);
    idle(50);
    get_rise(r1);
    chk(r1 - r0 == 0, "R12", "pulses after stop", r1 - r0, 0);
    rd(3'd6, v);
    chk(v[0] == 1'b0, "R12", "done after stop", v[0], 0);

    // R13 restart after stop measures full first run
    pattern(2, 4, 1, 16'h0, 1'b0, 1'b1, "R13");

    done_all = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule